// File: doc/BRIEF.md
# Regulator Startup Sequencer with Soft-Start DAC

This block is the supervisory controller of a multiphase voltage regulator. After power-on it waits for the enable input with healthy supplies. It then runs a calibration interval and a configuration interval, and waits for the gate-driver stage to report ready. Next it inspects the boot code. A nonzero boot code starts a soft-start ramp at once. A zero boot code parks the sequencer until a serial VID command delivers a target.

The reference DAC is a digital code. It moves toward its target by a fixed number of codes on every tick of an internal divider. The soft start always uses the slow step. Later target changes use either the slow step or the fast step, picked by an input.

During startup the over-voltage comparator is pointed at an absolute threshold, and OVP/UVP events cause no latch. In normal operation the threshold follows the DAC. An OVP event then latches the block: it forces all low-side switches on and ramps the DAC to zero. A UVP event latches the regulator-ready flag low. The regulator-ready flag rises a fixed delay after the DAC reaches its target. Dropping the enable, or any supply undervoltage, sends the block back to the disabled state.

Top module: `vr_start_seq`

## Requirements
- R1: While rst_n is low, state_o reads 0 (reset), dac_code_o, drv_en_o, vr_ready_o and force_ls_o read 0, and ovp_abs_sel_o reads 1. On the first edge after release, state_o becomes 1 (disabled). State codes: 0 reset, 1 disabled, 2 calibrate, 3 configure, 4 driver wait, 5 boot check, 6 VID wait, 7 soft start, 8 run, 9 OVP latch, 10 UVP latch.
- R2: From disabled with en_i high and no undervoltage flag, the order is calibrate for CAL_CYC+1 cycles, configure for CFG_CYC+1 cycles, then driver wait until drv_ok_i is high, then one cycle of boot check.
- R3: drv_en_o is low in reset, disabled, calibrate and configure. It is high in driver wait, boot check, VID wait, soft start, run and both latch states.
- R4: A nonzero boot_code_i sends boot check to soft start with that code as target. A zero boot_code_i sends it to VID wait, which holds dac_code_o at 0 until vid_valid_i. vid_code_i then becomes the target and soft start begins.
- R5: Soft start raises dac_code_o by SLOW_STEP codes every TICK_DIV cycles and never decreases it. The state is soft start for exactly T*TICK_DIV+1 cycles for a target T (with SLOW_STEP=1), after which it is run with dac_code_o equal to T.
- R6: In run, vid_valid_i loads vid_code_i as a new target. The DAC moves toward it by FAST_STEP codes per tick when fast_slew_i is 1, or SLOW_STEP when it is 0, and never passes it. Between any two cycles, a nonzero code differs from the previous code by at most FAST_STEP.
- R7: ovp_abs_sel_o is 1 (absolute startup threshold) in every state except run and the two latch states, where it is 0 (DAC-relative threshold).
- R8: In soft start, ovp_i freezes dac_code_o and drives force_ls_o high while it lasts, without a state change. uvp_i has no effect on the state in soft start.
- R9: vr_ready_o rises on the RDY_DLY+1-th clock edge after the edge that enters run. It stays high through target changes in run.
- R10: ovp_i in run enters the OVP latch. There force_ls_o is 1, the target is 0 and the DAC ramps down at the slow rate. vr_ready_o, if high, falls on the FALL_DLY+1-th edge after entry. The latch holds until a disable.
- R11: uvp_i in run (without ovp_i) enters the UVP latch. vr_ready_o is low from the next edge, and dac_code_o is frozen.
- R12: en_i low, vcc_uv_i high or vin_uv_i high puts the block in disabled on the next edge from any state, with dac_code_o, drv_en_o and vr_ready_o at 0. This is the only exit from either latch, and a new enable restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Regulator enable |
| vcc_uv_i | input | 1 | Controller supply undervoltage |
| vin_uv_i | input | 1 | Input rail undervoltage |
| drv_ok_i | input | 1 | Gate-driver stage ready |
| boot_code_i | input | DAC_W | Boot target code, 0 means wait for a command |
| vid_code_i | input | DAC_W | Commanded target code |
| vid_valid_i | input | 1 | One-cycle strobe loading vid_code_i |
| fast_slew_i | input | 1 | Fast step select for commanded changes |
| ovp_i | input | 1 | Over-voltage comparator flag |
| uvp_i | input | 1 | Under-voltage comparator flag |
| dac_code_o | output | DAC_W | Reference DAC code |
| drv_en_o | output | 1 | Driver enable |
| vr_ready_o | output | 1 | Regulator-ready flag |
| ovp_abs_sel_o | output | 1 | 1 selects absolute OVP threshold, 0 DAC-relative |
| force_ls_o | output | 1 | Force all low-side switches on |
| state_o | output | 4 | Sequencer state code |

## Verification
A wrong state shows at once on state_o and on the derived outputs drv_en_o and ovp_abs_sel_o. So the bench scoreboard compares each state transition against the expected order in the same cycle it happens. Faults in the counters appear only as a wrong duration: a calibrate, soft-start or ready-delay interval that is one cycle short or long. The bench therefore counts these intervals exactly, not just their end values. A latch that fails to hold shows up as a state change or a rising DAC code within a cycle of the exit. A ramp error shows up as a wrong settled code tens of cycles after the target change.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [3:0] {
    ST_RESET     = 4'd0,
    ST_OFF       = 4'd1,
    ST_CAL       = 4'd2,
    ST_CFG       = 4'd3,
    ST_DRV_WAIT  = 4'd4,
    ST_BOOT      = 4'd5,
    ST_VID_WAIT  = 4'd6,
    ST_SOFT      = 4'd7,
    ST_RUN       = 4'd8,
    ST_OVP_LATCH = 4'd9,
    ST_UVP_LATCH = 4'd10
  } seq_st_e;
endpackage

// File: rtl/vrs_tick_gen.sv
module vrs_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = !clr;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      assign tick = !clr && (cnt == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/vrs_delay.sv
module vrs_delay #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1) < 1 ? 1 : $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  assign done = (cnt == CW'(LIMIT));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!active)   cnt <= '0;
    else if (!done)     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/vrs_dac_ramp.sv
module vrs_dac_ramp #(
  parameter int W         = 8,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         hold,
  input  logic         fast,
  input  logic [W-1:0] tgt,
  output logic [W-1:0] code
);
  function automatic logic [W-1:0] step_toward(input logic [W-1:0] cur,
                                               input logic [W-1:0] goal,
                                               input logic [W-1:0] stp);
    if (cur < goal)      return ((goal - cur) > stp) ? cur + stp : goal;
    else if (cur > goal) return ((cur - goal) > stp) ? cur - stp : goal;
    else                 return cur;
  endfunction

  logic [W-1:0] step_sz;
  assign step_sz = fast ? W'(FAST_STEP) : W'(SLOW_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              code <= '0;
    else if (clr)            code <= '0;
    else if (tick && !hold)  code <= step_toward(code, tgt, step_sz);
  end
endmodule

// File: rtl/vr_start_seq.sv
module vr_start_seq
  import vrs_pkg::*;
#(
  parameter int DAC_W     = 8,
  parameter int TICK_DIV  = 4,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 4,
  parameter int CAL_CYC   = 6,
  parameter int CFG_CYC   = 5,
  parameter int RDY_DLY   = 10,
  parameter int FALL_DLY  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             vcc_uv_i,
  input  logic             vin_uv_i,
  input  logic             drv_ok_i,
  input  logic [DAC_W-1:0] boot_code_i,
  input  logic [DAC_W-1:0] vid_code_i,
  input  logic             vid_valid_i,
  input  logic             fast_slew_i,
  input  logic             ovp_i,
  input  logic             uvp_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             drv_en_o,
  output logic             vr_ready_o,
  output logic             ovp_abs_sel_o,
  output logic             force_ls_o,
  output logic [3:0]       state_o
);
  seq_st_e          st_q, st_d;
  logic [DAC_W-1:0] tgt_q, tgt_d;
  logic             ready_q, ready_d;

  // named internal events
  logic off_req, cal_done, cfg_done, rise_done, fall_done;
  logic at_target, ramp_tick, ramp_hold, ramp_clr, use_fast, ramp_state;

  assign off_req    = !en_i || vcc_uv_i || vin_uv_i;
  assign at_target  = (dac_code_o == tgt_q);
  assign ramp_state = (st_q == ST_SOFT) || (st_q == ST_RUN) ||
                      (st_q == ST_OVP_LATCH) || (st_q == ST_UVP_LATCH);
  assign ramp_clr   = !ramp_state || off_req;
  assign ramp_hold  = ((st_q == ST_SOFT) && ovp_i) || (st_q == ST_UVP_LATCH);
  assign use_fast   = (st_q == ST_RUN) && fast_slew_i;

  vrs_delay #(.LIMIT(CAL_CYC)) u_cal_tmr (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_CAL), .done(cal_done));
  vrs_delay #(.LIMIT(CFG_CYC)) u_cfg_tmr (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_CFG), .done(cfg_done));
  vrs_delay #(.LIMIT(RDY_DLY)) u_rise_tmr (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_RUN), .done(rise_done));
  vrs_delay #(.LIMIT(FALL_DLY)) u_fall_tmr (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_OVP_LATCH), .done(fall_done));

  vrs_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .tick(ramp_tick));

  vrs_dac_ramp #(.W(DAC_W), .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .tick(ramp_tick),
    .hold(ramp_hold), .fast(use_fast), .tgt(tgt_q), .code(dac_code_o));

  // next state
  always_comb begin
    st_d = st_q;
    if (st_q == ST_RESET) begin
      st_d = ST_OFF;
    end else if (off_req) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:       st_d = ST_CAL;
        ST_CAL:       if (cal_done) st_d = ST_CFG;
        ST_CFG:       if (cfg_done) st_d = ST_DRV_WAIT;
        ST_DRV_WAIT:  if (drv_ok_i) st_d = ST_BOOT;
        ST_BOOT:      st_d = (boot_code_i == '0) ? ST_VID_WAIT : ST_SOFT;
        ST_VID_WAIT:  if (vid_valid_i) st_d = ST_SOFT;
        ST_SOFT:      if (at_target && !ovp_i) st_d = ST_RUN;
        ST_RUN: begin
          if (ovp_i)      st_d = ST_OVP_LATCH;
          else if (uvp_i) st_d = ST_UVP_LATCH;
        end
        default:      st_d = st_q;
      endcase
    end
  end

  // target code
  always_comb begin
    tgt_d = tgt_q;
    if (off_req || st_q == ST_OFF) tgt_d = '0;
    else begin
      case (st_q)
        ST_BOOT:     if (boot_code_i != '0) tgt_d = boot_code_i;
        ST_VID_WAIT: if (vid_valid_i) tgt_d = vid_code_i;
        ST_RUN: begin
          if (ovp_i)                    tgt_d = '0;
          else if (!uvp_i && vid_valid_i) tgt_d = vid_code_i;
        end
        default: tgt_d = tgt_q;
      endcase
    end
  end

  // ready flag
  always_comb begin
    ready_d = 1'b0;
    if (!off_req) begin
      case (st_q)
        ST_RUN: begin
          if (uvp_i && !ovp_i) ready_d = 1'b0;
          else if (ovp_i)      ready_d = ready_q;
          else                 ready_d = rise_done;
        end
        ST_OVP_LATCH: ready_d = ready_q && !fall_done;
        default:      ready_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET;
      tgt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      ready_q <= ready_d;
    end
  end

  assign vr_ready_o    = ready_q;
  assign state_o       = st_q;
  assign drv_en_o      = (st_q == ST_DRV_WAIT) || (st_q == ST_BOOT) ||
                         (st_q == ST_VID_WAIT) || ramp_state;
  assign ovp_abs_sel_o = !((st_q == ST_RUN) || (st_q == ST_OVP_LATCH) ||
                           (st_q == ST_UVP_LATCH));
  assign force_ls_o    = (st_q == ST_OVP_LATCH) || ((st_q == ST_SOFT) && ovp_i);
endmodule

// File: rtl/vrs_chk.sv
module vrs_chk #(
  parameter int DAC_W     = 8,
  parameter int FAST_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             vcc_uv_i,
  input logic             vin_uv_i,
  input logic             ovp_i,
  input logic             uvp_i,
  input logic [3:0]       st,
  input logic [DAC_W-1:0] dac,
  input logic             drv_en,
  input logic             ready,
  input logic             abs_sel,
  input logic             force_ls
);
  logic off_c;
  assign off_c = !en_i || vcc_uv_i || vin_uv_i;

  p_off_on_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    off_c |=> (st == 4'd1 && !drv_en && !ready && dac == '0));

  p_ovp_latch_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd9 && !off_c) |=> (st == 4'd9 && force_ls));

  p_uvp_drops_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd8 && uvp_i && !ovp_i) |=> !ready);

  p_ready_context_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (drv_en && !abs_sel));

  p_dac_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac != '0) |-> (((dac >= $past(dac)) ? (dac - $past(dac)) : ($past(dac) - dac))
                     <= DAC_W'(FAST_STEP)));

  p_soft_rising_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd7 && $past(st) == 4'd7) |-> (dac >= $past(dac)));

  p_soft_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd7 && ovp_i && !off_c) |=> ($stable(dac) && st == 4'd7));
endmodule

bind vr_start_seq vrs_chk #(.DAC_W(DAC_W), .FAST_STEP(FAST_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .vcc_uv_i(vcc_uv_i), .vin_uv_i(vin_uv_i),
  .ovp_i(ovp_i), .uvp_i(uvp_i), .st(st_q), .dac(dac_code_o), .drv_en(drv_en_o),
  .ready(vr_ready_o), .abs_sel(ovp_abs_sel_o), .force_ls(force_ls_o));

// File: tb/vr_start_seq_tb.sv
`timescale 1ns/1ps
module vr_start_seq_tb;
  localparam int TICK = 4, CALC = 6, CFGC = 5, RDYD = 10, FALLD = 7;
  localparam int S_RST = 0, S_OFF = 1, S_CAL = 2, S_CFG = 3, S_DRV = 4, S_BOOT = 5,
                 S_VIDW = 6, S_SOFT = 7, S_RUN = 8, S_OVPL = 9, S_UVPL = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, vcc_uv = 0, vin_uv = 0, drv_ok = 0, vid_valid = 0, fast = 0, ovp = 0, uvp = 0;
  logic [7:0] boot = 0, vid = 0;
  logic [7:0] dac;
  logic drv_en, ready, abs_sel, force_ls;
  logic [3:0] st;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int exp_q[$];
  int last_st = S_RST;

  always #5 clk = ~clk;

  vr_start_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .vcc_uv_i(vcc_uv), .vin_uv_i(vin_uv),
    .drv_ok_i(drv_ok), .boot_code_i(boot), .vid_code_i(vid), .vid_valid_i(vid_valid),
    .fast_slew_i(fast), .ovp_i(ovp), .uvp_i(uvp), .dac_code_o(dac), .drv_en_o(drv_en),
    .vr_ready_o(ready), .ovp_abs_sel_o(abs_sel), .force_ls_o(force_ls), .state_o(st));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int s);
    exp_q.push_back(s);
  endtask

  // scoreboard monitor: every state change must match the next expected state
  always @(negedge clk) begin
    if (int'(st) != last_st) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected state change", int'(st), last_st);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(st) == e, "R2 state order", int'(st), e);
      end
      last_st = int'(st);
    end
  end

  task automatic wait_st(input int s, input int maxc, input string req);
    int c = 0;
    while (int'(st) != s && c < maxc) begin @(negedge clk); c++; end
    chk(int'(st) == s, req, int'(st), s);
  endtask

  task automatic pulse_vid(input logic [7:0] code);
    vid = code; vid_valid = 1; @(negedge clk); vid_valid = 0;
  endtask

  task automatic wait_ready(input string req);
    int c = 0;
    while (!ready && c < 40) begin @(negedge clk); c++; end
    chk(ready == 1'b1, req, ready, 1);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(st == 4'd0, "R1 reset state", st, 0);
    chk(dac == 0 && drv_en == 0 && ready == 0 && force_ls == 0, "R1 reset outputs",
        {dac, drv_en, ready, force_ls}, 0);
    chk(abs_sel == 1, "R1 reset abs threshold", abs_sel, 1);
    push(S_OFF);
    rst_n = 1;
    @(negedge clk);
    chk(st == S_OFF, "R1 disabled after reset", st, S_OFF);

    // first startup with nonzero boot code
    boot = 8'd20; en = 1; drv_ok = 0;
    push(S_CAL); push(S_CFG); push(S_DRV);
    wait_st(S_CAL, 5, "R2 enter calibrate");
    c = 0;
    while (st == S_CAL && c < 50) begin c++; @(negedge clk); end
    chk(c == CALC + 1, "R2 calibrate length", c, CALC + 1);
    chk(drv_en == 0, "R3 driver off in configure", drv_en, 0);
    wait_st(S_DRV, 20, "R2 enter driver wait");
    repeat (5) @(negedge clk);
    chk(st == S_DRV, "R2 holds for driver ready", st, S_DRV);
    chk(drv_en == 1, "R3 driver on in driver wait", drv_en, 1);
    push(S_BOOT); push(S_SOFT); push(S_RUN);
    drv_ok = 1;
    wait_st(S_SOFT, 5, "R4 nonzero boot goes to soft start");
    chk(abs_sel == 1, "R7 absolute threshold in soft start", abs_sel, 1);
    c = 0;
    while (st == S_SOFT && c < 200) begin c++; @(negedge clk); end
    chk(c == 20 * TICK + 1, "R5 soft start length", c, 20 * TICK + 1);
    chk(dac == 20, "R5 dac at boot target", dac, 20);
    chk(abs_sel == 0, "R7 relative threshold in run", abs_sel, 0);
    c = 0;
    while (!ready && c < 50) begin c++; @(negedge clk); end
    chk(c == RDYD + 1, "R9 ready delay", c, RDYD + 1);

    // commanded changes in run
    fast = 1; pulse_vid(8'd40);
    repeat (40) @(negedge clk);
    chk(dac == 40, "R6 fast ramp reaches target", dac, 40);
    pulse_vid(8'd42);
    repeat (20) @(negedge clk);
    chk(dac == 42, "R6 no overshoot on fast step", dac, 42);
    fast = 0; pulse_vid(8'd38);
    repeat (6) @(negedge clk);
    chk(dac >= 40, "R6 slow rate moves at most one code per tick", dac, 40);
    repeat (30) @(negedge clk);
    chk(dac == 38, "R6 slow ramp reaches target", dac, 38);
    chk(ready == 1, "R9 ready kept through target change", ready, 1);

    // disable
    push(S_OFF); en = 0;
    @(negedge clk);
    chk(st == S_OFF && drv_en == 0 && ready == 0 && dac == 0, "R12 disable clears",
        {st, drv_en, ready, dac}, {4'd1, 10'd0});

    // zero boot code path
    boot = 0; en = 1;
    push(S_CAL); push(S_CFG); push(S_DRV); push(S_BOOT); push(S_VIDW);
    wait_st(S_VIDW, 40, "R4 zero boot goes to VID wait");
    repeat (5) @(negedge clk);
    chk(st == S_VIDW && dac == 0, "R4 waits with dac at zero", dac, 0);
    push(S_SOFT); push(S_RUN);
    pulse_vid(8'd12);
    wait_st(S_SOFT, 3, "R4 command starts soft start");
    repeat (10) @(negedge clk);
    ovp = 1;
    @(negedge clk);
    chk(force_ls == 1, "R8 low sides forced on OVP in soft start", force_ls, 1);
    d0 = dac;
    repeat (8) @(negedge clk);
    chk(dac == d0, "R8 dac frozen on OVP in soft start", dac, d0);
    chk(st == S_SOFT, "R8 no latch in soft start", st, S_SOFT);
    ovp = 0; uvp = 1;
    repeat (8) @(negedge clk);
    chk(st == S_SOFT, "R8 UVP ignored in soft start", st, S_SOFT);
    uvp = 0;
    wait_st(S_RUN, 100, "R5 soft start completes");
    chk(dac == 12, "R4 dac at commanded target", dac, 12);
    wait_ready("R9 ready after second start");

    // OVP latch
    push(S_OVPL); ovp = 1;
    @(negedge clk);
    ovp = 0;
    chk(force_ls == 1, "R10 low sides forced in OVP latch", force_ls, 1);
    c = 0;
    while (ready && c < 50) begin c++; @(negedge clk); end
    chk(c == FALLD + 1, "R10 ready fall delay", c, FALLD + 1);
    repeat (60) @(negedge clk);
    chk(dac == 0, "R10 dac ramped to zero", dac, 0);
    chk(st == S_OVPL, "R10 latch holds", st, S_OVPL);

    // release by enable toggle and restart
    push(S_OFF); en = 0;
    @(negedge clk);
    chk(st == S_OFF && force_ls == 0, "R12 latch released by disable", st, S_OFF);
    boot = 8'd20; en = 1;
    push(S_CAL); push(S_CFG); push(S_DRV); push(S_BOOT); push(S_SOFT); push(S_RUN);
    wait_st(S_RUN, 200, "R12 restart reaches run");
    chk(dac == 20, "R12 restart dac at boot target", dac, 20);
    wait_ready("R9 ready after restart");

    // UVP latch
    push(S_UVPL); uvp = 1;
    @(negedge clk);
    uvp = 0;
    chk(st == S_UVPL && ready == 0, "R11 UVP drops ready", ready, 0);
    d0 = dac;
    repeat (10) @(negedge clk);
    chk(dac == d0 && st == S_UVPL, "R11 dac frozen and latched", dac, d0);

    // input undervoltage
    push(S_OFF); vin_uv = 1;
    @(negedge clk);
    chk(st == S_OFF && drv_en == 0 && dac == 0, "R12 undervoltage disables", st, S_OFF);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected states seen", exp_q.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule